// File: doc/BRIEF.md
# Hot-Swap Segment Join Controller

This block decides when a two-wire bus repeater may join its two bus segments. It watches the logic levels of the data and clock lines on both segments, two digitised supply-good flags and an active-high enable, and it drives one connect signal that gates the repeater's channel drivers. While either supply is not good, or while the enable is low, the segments stay apart.

When power and enable are both good, the controller first runs an initialisation interval of a fixed number of clock cycles. During this interval the bus is not watched. After it ends, the controller joins the segments on whichever comes first. One path is a STOP condition on the A segment while every line is high. The other is an unbroken stretch of all-high bus that lasts the idle time. Any low on any line restarts that stretch. Once joined, the link holds until enable or a supply flag drops. The controller then re-arms from the start, so a card plugged into a busy backplane joins only at a clean boundary in the traffic.

The four bus inputs pass through a multi-stage synchroniser before any decision is made. The enable and supply flags are taken as already synchronous to the clock.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While `pwr_a_ok` or `pwr_b_ok` is low, `connect_o` is 0. A supply flag that drops while connected clears `connect_o` in the same cycle.
- R2: While `en` is low, `connect_o` is 0 in the same cycle, whatever state the controller is in.
- R3: After power and enable become good, the first INIT_CYCLES clock cycles are an initialisation interval. A STOP or an idle bus during this interval does not lead to a connection.
- R4: STOP detection and idle timing start only in the cycle after the initialisation interval ends.
- R5: After initialisation, `connect_o` goes to 1 once all four synchronised lines have been high for IDLE_CYCLES consecutive monitored cycles and are still high.
- R6: A low on any of the four lines, even for one cycle, restarts the idle count. Traffic whose gaps are shorter than IDLE_CYCLES never connects unless a STOP occurs.
- R7: After initialisation, a STOP on the A segment connects. A STOP is synchronised A-SDA going from 0 to 1 while synchronised A-SCL is 1 in both the current and the previous sample, with the B lines also high.
- R8: Once connected, `connect_o` stays 1 until `en` or a supply flag goes low. After that, a full initialisation and a fresh STOP or idle interval are needed before it connects again.
- R9: The bus inputs go through SYNC_STAGES flops. `connect_o` rises right after the (SYNC_STAGES+1)-th rising clock edge that samples the A-SDA rise of a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Active-high repeater enable |
| pwr_a_ok | input | 1 | A-side supply above its good level |
| pwr_b_ok | input | 1 | B-side supply above its good level |
| sda_a_in | input | 1 | Raw level of A-side data line |
| scl_a_in | input | 1 | Raw level of A-side clock line |
| sda_b_in | input | 1 | Raw level of B-side data line |
| scl_b_in | input | 1 | Raw level of B-side clock line |
| connect_o | output | 1 | 1 = channel drivers may join the segments |

## Verification
A wrong internal state shows up on `connect_o` within one clock. A controller stuck in initialisation or monitoring never raises it. One that leaves initialisation early, or mis-counts the idle stretch, raises it a cycle or more before the reference says it should. An idle counter that misses a one-cycle low shows up as a connection in the middle of traffic. A STOP detector that also looks at a rising A-SCL, or that uses the wrong sample, connects at a START or at a clock edge, or connects late by the synchroniser depth. The reference model follows the same timing and compares `connect_o` on every cycle, so any such error shows in the first cycle it occurs.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
   typedef enum logic [1:0] {
      HS_OFF   = 2'd0,
      HS_INIT  = 2'd1,
      HS_WATCH = 2'd2,
      HS_LINK  = 2'd3
   } hs_state_e;
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hsc_sync: W must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      pipe[i] <= '1;
         else if (i == 0) pipe[i] <= d;
         else             pipe[i] <= pipe[(i == 0) ? 0 : i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsc_stop_det.sv
module hsc_stop_det #(
   parameter bit STOP_FAST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sda,
   input  logic scl,
   output logic stop_hit
);
   logic sda_prev, scl_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sda_prev <= 1'b1;
         scl_prev <= 1'b1;
      end else begin
         sda_prev <= sda;
         scl_prev <= scl;
      end
   end

   if (STOP_FAST) begin : g_stop
      assign stop_hit = sda & ~sda_prev & scl & scl_prev;
   end else begin : g_no_stop
      assign stop_hit = 1'b0 & sda & sda_prev & scl & scl_prev;
   end
endmodule

// File: rtl/hsc_idle_timer.sv
module hsc_idle_timer #(
   parameter int IDLE_CYCLES = 26250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic bus_high,
   output logic idle_done
);
   localparam int CW = $clog2(IDLE_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

   if (IDLE_CYCLES < 2) begin : g_bad_idle
      $error("hsc_idle_timer: IDLE_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!arm || !bus_high) cnt_q <= '0;
      else if (cnt_q != LIMIT)    cnt_q <= cnt_q + 1'b1;
   end

   assign idle_done = (cnt_q == LIMIT);
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int INIT_CYCLES = 256,
   parameter int IDLE_CYCLES = 26250,
   parameter bit STOP_FAST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pwr_a_ok,
   input  logic pwr_b_ok,
   input  logic sda_a_in,
   input  logic scl_a_in,
   input  logic sda_b_in,
   input  logic scl_b_in,
   output logic connect_o
);
   import hsc_pkg::*;

   localparam int ICW = (INIT_CYCLES > 2) ? $clog2(INIT_CYCLES) : 1;
   localparam logic [ICW-1:0] INIT_LAST = ICW'(INIT_CYCLES - 1);

   if (INIT_CYCLES < 2) begin : g_bad_init
      $error("hotswap_link_ctrl: INIT_CYCLES must be at least 2");
   end

   // bit 3 A-SDA, bit 2 A-SCL, bit 1 B-SDA, bit 0 B-SCL
   logic [3:0] lines_s;
   logic       all_high, stop_hit, idle_done, live;
   hs_state_e  state_q, state_d;
   logic [ICW-1:0] init_cnt_q;

   hsc_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sda_a_in, scl_a_in, sda_b_in, scl_b_in}),
      .q     (lines_s)
   );

   hsc_stop_det #(.STOP_FAST(STOP_FAST)) u_stop (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda      (lines_s[3]),
      .scl      (lines_s[2]),
      .stop_hit (stop_hit)
   );

   assign all_high = &lines_s;
   assign live     = en & pwr_a_ok & pwr_b_ok;

   hsc_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (state_q == HS_WATCH),
      .bus_high  (all_high),
      .idle_done (idle_done)
   );

   always_comb begin
      state_d = state_q;
      if (!live) begin
         state_d = HS_OFF;
      end else begin
         unique case (state_q)
            HS_OFF:   state_d = HS_INIT;
            HS_INIT:  if (init_cnt_q == INIT_LAST) state_d = HS_WATCH;
            HS_WATCH: if (all_high && (stop_hit || idle_done)) state_d = HS_LINK;
            HS_LINK:  state_d = HS_LINK;
            default:  state_d = HS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= HS_OFF;
         init_cnt_q <= '0;
      end else begin
         state_q    <= state_d;
         init_cnt_q <= (state_q == HS_INIT) ? init_cnt_q + 1'b1 : '0;
      end
   end

   // enable and supply gate the output directly so a drop disconnects at once
   assign connect_o = (state_q == HS_LINK) & live;
endmodule

// File: rtl/hsc_link_checker.sv
module hsc_link_checker (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             pwr_a_ok,
   input logic             pwr_b_ok,
   input logic             connect_o,
   input hsc_pkg::hs_state_e state,
   input logic             bus_high
);
   import hsc_pkg::*;

   assert_unpowered_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_a_ok && pwr_b_ok) |=> !connect_o);

   assert_en_low_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !connect_o);

   assert_watch_after_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == HS_WATCH) |-> $past(state == HS_INIT || state == HS_WATCH));

   assert_link_from_watch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == HS_LINK) |-> $past(state == HS_WATCH || state == HS_LINK));

   assert_join_on_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connect_o) |-> $past(bus_high));
endmodule

bind hotswap_link_ctrl hsc_link_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .pwr_a_ok  (pwr_a_ok),
   .pwr_b_ok  (pwr_b_ok),
   .connect_o (connect_o),
   .state     (state_q),
   .bus_high  (all_high)
);

// File: tb/hotswap_link_ctrl_bench.sv
module hotswap_link_ctrl_bench;
   localparam int SYNC = 2;
   localparam int INIT = 12;
   localparam int IDLE = 40;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, en, pa, pb, sda_a, scl_a, sda_b, scl_b;
   logic connect_o;
   int   vectors = 0, miscompares = 0, cyc = 0;
   string cur_req = "R1";

   hotswap_link_ctrl #(.SYNC_STAGES(SYNC), .INIT_CYCLES(INIT), .IDLE_CYCLES(IDLE)) u_hotswap_link_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .pwr_a_ok(pa), .pwr_b_ok(pb),
      .sda_a_in(sda_a), .scl_a_in(scl_a), .sda_b_in(sda_b), .scl_b_in(scl_b),
      .connect_o(connect_o));

   // behavioural reference: 0 off, 1 init, 2 watching, 3 joined
   logic [3:0] dly_q[$];
   logic [1:0] m_prev;
   int m_st, m_ic, m_idle;

   always @(posedge clk) begin
      logic [3:0] s;
      logic hi, stp, done;
      int nst;
      if (!rst_n) begin
         dly_q.delete();
         for (int i = 0; i < SYNC; i++) dly_q.push_back(4'hF);
         m_prev = 2'b11; m_st = 0; m_ic = 0; m_idle = 0;
      end else begin
         s    = dly_q[0];
         hi   = (s == 4'hF);
         stp  = s[3] && !m_prev[1] && s[2] && m_prev[0];
         done = (m_idle >= IDLE);
         nst  = m_st;
         if (!(en && pa && pb)) nst = 0;
         else if (m_st == 0) nst = 1;
         else if (m_st == 1 && m_ic == INIT-1) nst = 2;
         else if (m_st == 2 && hi && (stp || done)) nst = 3;
         m_ic   = (m_st == 1) ? m_ic + 1 : 0;
         m_idle = (m_st == 2 && hi) ? ((m_idle < IDLE) ? m_idle + 1 : m_idle) : 0;
         m_st   = nst;
         m_prev = s[3:2];
         void'(dly_q.pop_front());
         dly_q.push_back({sda_a, scl_a, sda_b, scl_b});
      end
   end

   always @(negedge clk) begin
      logic exp;
      if (rst_n) begin
         exp = (m_st == 3) && en && pa && pb;
         vectors++;
         if (connect_o !== exp) begin
            miscompares++;
            $display("FAIL %s cycle %0d: connect_o=%b expected %b", cur_req, cyc, connect_o, exp);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_link(input logic want, input string req);
      @(negedge clk);
      vectors++;
      if (connect_o !== want) begin
         miscompares++;
         $display("FAIL %s: connect_o=%b expected %b", req, connect_o, want);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         miscompares++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected end before 100000", cyc);
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; en = 1'b1; pa = 1'b0; pb = 1'b1;
      sda_a = 1'b1; scl_a = 1'b1; sda_b = 1'b1; scl_b = 1'b1;
      step(4);
      rst_n = 1'b1;
      expect_link(1'b0, "R1");
      step(60);
      expect_link(1'b0, "R1");          // supply A never good: stays apart

      cur_req = "R3";                   // idle bus, init then idle timer
      pa = 1'b1;
      step(INIT + SYNC);
      expect_link(1'b0, "R3");
      cur_req = "R5";
      step(IDLE + 10);
      expect_link(1'b1, "R5");

      cur_req = "R2";
      en = 1'b0;
      expect_link(1'b0, "R2");          // same cycle drop
      step(3);

      cur_req = "R6";                   // busy B side, gaps shorter than idle
      en = 1'b1;
      for (int k = 0; k < 30; k++) begin
         scl_b = 1'b0; step(2);
         scl_b = 1'b1; step(IDLE - 10);
      end
      expect_link(1'b0, "R6");
      sda_b = 1'b0; step(1); sda_b = 1'b1; // one-cycle low restarts count
      step(IDLE - 5);
      expect_link(1'b0, "R6");

      cur_req = "R7";                   // STOP on A side joins early
      scl_a = 1'b0; step(3);
      sda_a = 1'b0; step(3);
      scl_a = 1'b1; step(3);
      sda_a = 1'b1;
      step(SYNC);
      expect_link(1'b0, "R9");
      step(1);
      expect_link(1'b1, "R7");

      cur_req = "R8";                   // supply blip re-arms
      pa = 1'b0;
      expect_link(1'b0, "R1");
      step(1);
      pa = 1'b1;
      step(INIT);
      expect_link(1'b0, "R8");
      step(IDLE + 10);
      expect_link(1'b1, "R8");

      cur_req = "R4";                   // STOP during init is ignored
      en = 1'b0; step(2);
      en = 1'b1;
      sda_a = 1'b0; step(1);
      sda_a = 1'b1; step(3);
      for (int k = 0; k < 4; k++) begin
         step(IDLE - 10);
         sda_b = 1'b0; step(1); sda_b = 1'b1;
      end
      expect_link(1'b0, "R4");
      cur_req = "R5";
      step(IDLE + 10);
      expect_link(1'b1, "R5");

      cur_req = "R2";
      en = 1'b0; step(5);
      expect_link(1'b0, "R2");
      finish_run();
   end
endmodule